// File: doc/BRIEF.md
# Dual-Page-Size Translation Lookaside Buffer

This block is a first-level address translation cache. It turns a 48-bit virtual address into a 40-bit physical address. It keeps two fully associative pools of translations, one for 4 KB pages and one for large pages, and searches both on every lookup. The result is registered and appears on the clock edge after the request. It carries the hit flag, the physical address and the writable and user-accessible permission bits of the matching entry.

Translations enter through a fill port. The port carries the virtual and physical page numbers above bit 12 and a page-size code, and the code decides which pool receives the entry. Entries have no address-space tag. Software therefore pulses the flush input on every context switch, and that pulse drops all translations in one cycle. Each pool chooses its victim by itself. A free slot is taken first. When none is free, a per-pool rotating pointer picks the slot.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup requested with `lk_req` in cycle N is answered in cycle N+1 with `lk_ack` high for exactly that cycle. With no request, `lk_ack` stays low.
- R2: A 4 KB entry matches when virtual bits [47:12] equal its stored page number. On a hit the physical address is {stored page, va[11:0]}, and the stored writable and user bits are returned.
- R3: A 2 MB entry matches on virtual bits [47:21]. The physical address is {stored pa[39:21], va[20:0]}. A neighbouring 2 MB region misses.
- R4: A 4 MB entry matches on virtual bits [47:22]. The physical address is {stored pa[39:22], va[21:0]}, so bit 21 of the result is taken from the lookup address whatever bit 21 of the filled addresses held.
- R5: `fill_size` 2'b00 writes the 32-entry small pool, 2'b01 writes a 2 MB entry and 2'b10 or 2'b11 writes a 4 MB entry into the 8-entry large pool. Filling one pool never evicts an entry of the other.
- R6: When several entries match, a small-page entry wins over a large one, and inside a pool the lowest slot wins. `lk_multi` is high with the result whenever more than one entry matched.
- R7: A fill goes to the lowest-numbered invalid slot of its pool while one exists, and the rotating pointer is left unchanged.
- R8: When its pool is full, a fill replaces the slot at that pool's pointer, and the pointer then advances by one and wraps. Flush does not move the pointer.
- R9: A flush pulse invalidates all entries in one cycle. A lookup in the flush cycle reports a miss, and a fill in the flush cycle is dropped.
- R10: Synchronous active-high reset empties both pools and zeroes the pointers. While `lk_ack` is low, `lk_hit`, `lk_multi`, `lk_wr`, `lk_usr` and `lk_pa` are all zero. A miss also returns zero address and permissions.
- R11: A lookup in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 48 | Virtual address to translate |
| lk_ack | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Translation found |
| lk_pa | output | 40 | Translated physical address |
| lk_wr | output | 1 | Page is writable |
| lk_usr | output | 1 | Page is user-accessible |
| lk_multi | output | 1 | More than one entry matched |
| fill_en | input | 1 | Write one translation |
| fill_vpn | input | 36 | Virtual address bits [47:12] of the new translation |
| fill_ppn | input | 28 | Physical address bits [39:12] of the new translation |
| fill_size | input | 2 | Page size: 00 = 4 KB, 01 = 2 MB, 1x = 4 MB |
| fill_wr | input | 1 | Writable bit for the new entry |
| fill_usr | input | 1 | User-accessible bit for the new entry |
| flush | input | 1 | Invalidate every entry |

## Verification
The assertions check the request-to-response timing every cycle, along with the zeroed outputs of idle and miss cycles. They also check that the low 12 physical bits of every hit copy the looked-up address, that a multi-hit never comes without a hit, and that lookups during or right after a flush miss. Only the bench scenarios can show the rest. This covers which slot a fill lands in and how the rotating pointer moves across evictions and flushes. It also covers the large-page masking of bits 21 and 22, the small-over-large priority in overlapping regions, and the lookup-before-fill ordering. Each of these needs a sequence of fills followed by lookups whose hits and misses reveal the stored contents.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    PG_4K     = 2'b00,
    PG_2M     = 2'b01,
    PG_4M     = 2'b10,
    PG_4M_ALT = 2'b11
  } pg_size_e;

  function automatic logic pg_is_small(input logic [1:0] code);
    return pg_size_e'(code) == PG_4K;
  endfunction

  function automatic logic pg_is_4m(input logic [1:0] code);
    return code[1];
  endfunction
endpackage

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  slot_vld,
  input  logic          fill_go,
  output logic [IW-1:0] fill_idx
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr_q;
  logic          has_free;

  // lowest invalid slot wins, otherwise the rotating pointer
  always_comb begin
    has_free = 1'b0;
    fill_idx = ptr_q;
    for (int i = N - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        has_free = 1'b1;
        fill_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (fill_go && !has_free) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_pool.sv
module xlat_pool #(
  parameter int N     = 32,
  parameter int VA_W  = 48,
  parameter int PA_W  = 40,
  parameter int OFF_W = 12,
  parameter int IW    = $clog2(N)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  flush,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_idx,
  input  logic [VA_W-OFF_W-1:0] wr_tag,
  input  logic [PA_W-OFF_W-1:0] wr_ppn,
  input  logic                  wr_msk,
  input  logic                  wr_w,
  input  logic                  wr_u,
  input  logic [VA_W-1:0]       lk_va,
  output logic [N-1:0]          vld_o,
  output logic                  hit_any,
  output logic                  hit_more,
  output logic [PA_W-1:0]       hit_pa,
  output logic                  hit_w,
  output logic                  hit_u
);
  localparam int TW = VA_W - OFF_W;
  localparam int PW = PA_W - OFF_W;

  logic [N-1:0]  vld_q;
  logic [TW-1:0] tag_q [N];
  logic [PW-1:0] ppn_q [N];
  logic [N-1:0]  msk_q, w_q, u_q;
  logic [N-1:0]  match;
  logic [TW-1:0] va_tag;

  assign va_tag = lk_va[VA_W-1:OFF_W];
  assign vld_o  = vld_q;

  // valid bits: the only state touched by reset and flush
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  // payload: plain write port, no reset
  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx] <= wr_tag;
      ppn_q[wr_idx] <= wr_ppn;
      msk_q[wr_idx] <= wr_msk;
      w_q[wr_idx]   <= wr_w;
      u_q[wr_idx]   <= wr_u;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [TW-1:0] diff;
    assign diff     = (tag_q[g] ^ va_tag) & ~{{(TW-1){1'b0}}, msk_q[g]};
    assign match[g] = vld_q[g] && (diff == '0);
  end

  logic [PW-1:0] sel_ppn;
  logic          sel_msk;

  always_comb begin
    sel_ppn = '0;
    sel_msk = 1'b0;
    hit_w   = 1'b0;
    hit_u   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel_ppn = ppn_q[i];
        sel_msk = msk_q[i];
        hit_w   = w_q[i];
        hit_u   = u_q[i];
      end
    end
  end

  assign hit_any  = |match;
  assign hit_more = |(match & (match - N'(1)));
  assign hit_pa   = {sel_msk ? {sel_ppn[PW-1:1], va_tag[0]} : sel_ppn,
                     lk_va[OFF_W-1:0]};
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int SM_N   = 32,
  parameter int LG_N   = 8,
  parameter int SM_OFF = 12,
  parameter int LG_OFF = 21
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_req,
  input  logic [VA_W-1:0]        lk_va,
  output logic                   lk_ack,
  output logic                   lk_hit,
  output logic [PA_W-1:0]        lk_pa,
  output logic                   lk_wr,
  output logic                   lk_usr,
  output logic                   lk_multi,
  input  logic                   fill_en,
  input  logic [VA_W-SM_OFF-1:0] fill_vpn,
  input  logic [PA_W-SM_OFF-1:0] fill_ppn,
  input  logic [1:0]             fill_size,
  input  logic                   fill_wr,
  input  logic                   fill_usr,
  input  logic                   flush
);
  localparam int SM_IW = $clog2(SM_N);
  localparam int LG_IW = $clog2(LG_N);
  localparam int SHIFT = LG_OFF - SM_OFF;

  logic fill_go, sm_go, lg_go;
  assign fill_go = fill_en && !flush;
  assign sm_go   = fill_go && pg_is_small(fill_size);
  assign lg_go   = fill_go && !pg_is_small(fill_size);

  logic [SM_N-1:0]  sm_vld;
  logic [LG_N-1:0]  lg_vld;
  logic [SM_IW-1:0] sm_idx;
  logic [LG_IW-1:0] lg_idx;

  xlat_victim #(.N(SM_N), .IW(SM_IW)) u_sm_vic (
    .clk(clk), .rst(rst), .slot_vld(sm_vld), .fill_go(sm_go), .fill_idx(sm_idx)
  );

  xlat_victim #(.N(LG_N), .IW(LG_IW)) u_lg_vic (
    .clk(clk), .rst(rst), .slot_vld(lg_vld), .fill_go(lg_go), .fill_idx(lg_idx)
  );

  logic            sm_any, sm_more, sm_w, sm_u;
  logic            lg_any, lg_more, lg_w, lg_u;
  logic [PA_W-1:0] sm_pa, lg_pa;

  xlat_pool #(.N(SM_N), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(SM_OFF), .IW(SM_IW)) u_sm (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(sm_go), .wr_idx(sm_idx),
    .wr_tag(fill_vpn), .wr_ppn(fill_ppn), .wr_msk(1'b0),
    .wr_w(fill_wr), .wr_u(fill_usr),
    .lk_va(lk_va), .vld_o(sm_vld),
    .hit_any(sm_any), .hit_more(sm_more), .hit_pa(sm_pa), .hit_w(sm_w), .hit_u(sm_u)
  );

  xlat_pool #(.N(LG_N), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(LG_OFF), .IW(LG_IW)) u_lg (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(lg_go), .wr_idx(lg_idx),
    .wr_tag(fill_vpn[VA_W-SM_OFF-1:SHIFT]), .wr_ppn(fill_ppn[PA_W-SM_OFF-1:SHIFT]),
    .wr_msk(pg_is_4m(fill_size)),
    .wr_w(fill_wr), .wr_u(fill_usr),
    .lk_va(lk_va), .vld_o(lg_vld),
    .hit_any(lg_any), .hit_more(lg_more), .hit_pa(lg_pa), .hit_w(lg_w), .hit_u(lg_u)
  );

  logic hit_c, multi_c;
  assign hit_c   = lk_req && !flush && (sm_any || lg_any);
  assign multi_c = lk_req && !flush && (sm_more || lg_more || (sm_any && lg_any));

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_ack   <= 1'b0;
      lk_hit   <= 1'b0;
      lk_pa    <= '0;
      lk_wr    <= 1'b0;
      lk_usr   <= 1'b0;
      lk_multi <= 1'b0;
    end else begin
      lk_ack   <= lk_req;
      lk_hit   <= hit_c;
      lk_multi <= multi_c;
      if (!hit_c) begin
        lk_pa  <= '0;
        lk_wr  <= 1'b0;
        lk_usr <= 1'b0;
      end else if (sm_any) begin
        lk_pa  <= sm_pa;
        lk_wr  <= sm_w;
        lk_usr <= sm_u;
      end else begin
        lk_pa  <= lg_pa;
        lk_wr  <= lg_w;
        lk_usr <= lg_u;
      end
    end
  end
endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int SM_N   = 32,
  parameter int LG_N   = 8,
  parameter int SM_OFF = 12,
  parameter int LG_OFF = 21
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   lk_req,
  input logic [VA_W-1:0]        lk_va,
  input logic                   lk_ack,
  input logic                   lk_hit,
  input logic [PA_W-1:0]        lk_pa,
  input logic                   lk_wr,
  input logic                   lk_usr,
  input logic                   lk_multi,
  input logic                   fill_en,
  input logic [VA_W-SM_OFF-1:0] fill_vpn,
  input logic [PA_W-SM_OFF-1:0] fill_ppn,
  input logic [1:0]             fill_size,
  input logic                   fill_wr,
  input logic                   fill_usr,
  input logic                   flush
);
  p_ack_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_ack);

  p_no_stray_ack_r1: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_ack);

  p_offset_passthru_r2: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> (!lk_hit || lk_pa[SM_OFF-1:0] == $past(lk_va[SM_OFF-1:0])));

  p_multi_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
    lk_multi |-> lk_hit);

  p_flush_cycle_miss_r9: assert property (@(posedge clk) disable iff (rst)
    (flush && lk_req) |=> !lk_hit);

  p_after_flush_miss_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && lk_req) |=> !lk_hit);

  p_quiet_outputs_r10: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_pa == '0 && !lk_wr && !lk_usr && !lk_multi));
endmodule

bind xlat_buffer xlat_buffer_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .SM_N(SM_N), .LG_N(LG_N), .SM_OFF(SM_OFF), .LG_OFF(LG_OFF)
) u_chk (.*);

// File: tb/xlat_buffer_test.sv
module xlat_buffer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [47:0] lk_va = '0;
  logic        lk_ack, lk_hit, lk_wr, lk_usr, lk_multi;
  logic [39:0] lk_pa;
  logic        fill_en = 1'b0;
  logic [35:0] fill_vpn = '0;
  logic [27:0] fill_ppn = '0;
  logic [1:0]  fill_size = 2'b00;
  logic        fill_wr = 1'b0, fill_usr = 1'b0;
  logic        flush = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xlat_buffer uut (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_va(lk_va),
    .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_wr(lk_wr),
    .lk_usr(lk_usr), .lk_multi(lk_multi),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_size(fill_size), .fill_wr(fill_wr), .fill_usr(fill_usr), .flush(flush)
  );

  typedef struct {
    logic        hit;
    logic [39:0] pa;
    logic        w;
    logic        u;
    logic        m;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic tick();
    @(posedge clk);
    #1;
    lk_req  = 1'b0;
    fill_en = 1'b0;
    flush   = 1'b0;
  endtask

  // drive fill signals without advancing time
  task automatic set_fill(input logic [47:0] va, input logic [39:0] pa,
                          input logic [1:0] sz, input logic w, input logic u);
    fill_en   = 1'b1;
    fill_vpn  = va[47:12];
    fill_ppn  = pa[39:12];
    fill_size = sz;
    fill_wr   = w;
    fill_usr  = u;
  endtask

  task automatic fill(input logic [47:0] va, input logic [39:0] pa,
                      input logic [1:0] sz, input logic w, input logic u);
    set_fill(va, pa, sz, w, u);
    tick();
  endtask

  // driver: push the expectation, issue the request for one cycle
  task automatic look(input logic [47:0] va, input logic h, input logic [39:0] pa,
                      input logic w, input logic u, input logic m, input string tag);
    exp_t e;
    e.hit = h; e.pa = h ? pa : '0; e.w = h & w; e.u = h & u; e.m = m; e.tag = tag;
    sb.push_back(e);
    lk_req = 1'b1;
    lk_va  = va;
    tick();
  endtask

  task automatic miss(input logic [47:0] va, input string tag);
    look(va, 1'b0, '0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare each result against the oldest expectation
  always @(negedge clk) begin
    if (!rst && lk_ack) begin
      n_run++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL R1: unexpected lk_ack, actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (lk_hit !== e.hit || lk_pa !== e.pa || lk_wr !== e.w ||
            lk_usr !== e.u || lk_multi !== e.m) begin
          n_fail++;
          $display("FAIL %s: actual hit=%b pa=%h w=%b u=%b m=%b expected hit=%b pa=%h w=%b u=%b m=%b",
                   e.tag, lk_hit, lk_pa, lk_wr, lk_usr, lk_multi,
                   e.hit, e.pa, e.w, e.u, e.m);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    n_run++;
    if (lk_ack !== 1'b0 || lk_hit !== 1'b0 || lk_pa !== '0 || lk_multi !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: reset outputs actual ack=%b hit=%b pa=%h expected 0 0 0",
               lk_ack, lk_hit, lk_pa);
    end
    rst = 1'b0;
    tick();

    miss(48'h0000_1234_5678, "R10 empty after reset");

    // R11 then R2: lookup in the fill cycle sees the old contents
    set_fill(48'h0000_1234_5000, 40'h12_3456_7000, 2'b00, 1'b1, 1'b0);
    miss(48'h0000_1234_5ABC, "R11 same-cycle fill");
    look(48'h0000_1234_5ABC, 1'b1, 40'h12_3456_7ABC, 1'b1, 1'b0, 1'b0, "R2 small hit");
    miss(48'h0000_1234_6ABC, "R2 next page misses");

    // R3 2 MB page
    fill(48'h7F00_0020_0000, 40'h40_0020_0000, 2'b01, 1'b0, 1'b1);
    look(48'h7F00_003F_F123, 1'b1, 40'h40_003F_F123, 1'b0, 1'b1, 1'b0, "R3 2MB hit");
    miss(48'h7F00_0040_0000, "R3 next 2MB region");

    // R4 4 MB page, bit 21 from lookup
    fill(48'h1000_0040_0000, 40'h80_0000_0000, 2'b10, 1'b1, 1'b1);
    look(48'h1000_0060_0010, 1'b1, 40'h80_0020_0010, 1'b1, 1'b1, 1'b0, "R4 4MB hit upper half");
    look(48'h1000_0040_0010, 1'b1, 40'h80_0000_0010, 1'b1, 1'b1, 1'b0, "R4 4MB hit lower half");
    miss(48'h1000_0080_0000, "R4 next 4MB region");

    // R6 small wins over overlapping large, multi flagged
    fill(48'h7F00_0030_0000, 40'h05_5555_5000, 2'b00, 1'b1, 1'b1);
    look(48'h7F00_0030_0040, 1'b1, 40'h05_5555_5040, 1'b1, 1'b1, 1'b1, "R6 small over large");
    look(48'h7F00_0020_0040, 1'b1, 40'h40_0020_0040, 1'b0, 1'b1, 1'b0, "R6 large only");
    fill(48'h0000_1234_5000, 40'h22_2222_2000, 2'b00, 1'b0, 1'b1);
    look(48'h0000_1234_5010, 1'b1, 40'h12_3456_7010, 1'b1, 1'b0, 1'b1, "R6 lowest slot in pool");

    // R9 flush with same-cycle lookup and fill
    flush = 1'b1;
    set_fill(48'h0E00_0000_0000, 40'h0E_0000_0000, 2'b00, 1'b1, 1'b1);
    miss(48'h0000_1234_5010, "R9 lookup in flush cycle");
    miss(48'h0000_1234_5010, "R9 small cleared");
    miss(48'h7F00_0020_0040, "R9 large cleared");
    miss(48'h0E00_0000_0000, "R9 fill in flush cycle dropped");

    // R8 rotating replacement in the small pool (pointer starts at 0)
    for (int k = 0; k < 34; k++)
      fill(48'h0A00_0000_0000 + (48'(k) << 12), 40'h01_0000_0000 + (40'(k) << 12),
           2'b00, 1'b1, 1'b0);
    miss(48'h0A00_0000_0000, "R8 first eviction slot 0");
    miss(48'h0A00_0000_1000, "R8 second eviction slot 1");
    look(48'h0A00_0000_2004, 1'b1, 40'h01_0000_2004, 1'b1, 1'b0, 1'b0, "R8 slot 2 kept");
    look(48'h0A00_0002_0008, 1'b1, 40'h01_0002_0008, 1'b1, 1'b0, 1'b0, "R8 newest in slot 0");
    look(48'h0A00_0002_1008, 1'b1, 40'h01_0002_1008, 1'b1, 1'b0, 1'b0, "R8 newest in slot 1");

    // R7 free slot first, pointer (now 2) survives flush
    flush = 1'b1;
    tick();
    for (int k = 0; k < 33; k++)
      fill(48'h0B00_0000_0000 + (48'(k) << 12), 40'h02_0000_0000 + (40'(k) << 12),
           2'b00, 1'b0, 1'b1);
    look(48'h0B00_0000_0001, 1'b1, 40'h02_0000_0001, 1'b0, 1'b1, 1'b0, "R7 free slot used first");
    miss(48'h0B00_0000_2001, "R8 pointer kept across flush");
    look(48'h0B00_0000_1001, 1'b1, 40'h02_0000_1001, 1'b0, 1'b1, 1'b0, "R7 slot 1 kept");
    look(48'h0B00_0002_0001, 1'b1, 40'h02_0002_0001, 1'b0, 1'b1, 1'b0, "R8 replacement hit");

    // R5 large pool holds 8, separate from small pool
    for (int j = 0; j < 9; j++)
      fill(48'h0C00_0000_0000 + (48'(j) << 21), 40'h20_0000_0000 + (40'(j) << 21),
           2'b01, 1'b1, 1'b1);
    miss(48'h0C00_0000_0100, "R5 large pool capacity 8");
    look(48'h0C00_0100_0100, 1'b1, 40'h20_0100_0100, 1'b1, 1'b1, 1'b0, "R5 ninth large entry");
    look(48'h0C00_00E0_0100, 1'b1, 40'h20_00E0_0100, 1'b1, 1'b1, 1'b0, "R5 eighth large entry");
    look(48'h0B00_0000_1002, 1'b1, 40'h02_0000_1002, 1'b0, 1'b1, 1'b0, "R5 small untouched");

    // R5 code 2'b11 is 4 MB; R4 filled bit 21 ignored
    fill(48'h0D00_0020_0000, 40'h30_0000_0000, 2'b11, 1'b0, 1'b0);
    look(48'h0D00_0010_0000, 1'b1, 40'h30_0010_0000, 1'b0, 1'b0, 1'b0, "R5 code 11 as 4MB");
    look(48'h0D00_0030_0000, 1'b1, 40'h30_0030_0000, 1'b0, 1'b0, 1'b0, "R4 bit 21 from lookup");

    repeat (3) tick();
    n_run++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R1: pending results actual %0d expected 0", sb.size());
    end
    finish_run();
  end
endmodule